// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit treats its two 64-bit source operands as vectors of equal-width integer lanes: eight lanes of 8 bits, four of 16, two of 32, or one of 64. A single issue applies one operation to every lane at once. The available operations are wrapping add and subtract, signed and unsigned saturating add and subtract, full-width bitwise logic, pack operations that halve the element width, and unpack operations that interleave half-width elements into full lanes.

Each lane has a disable bit. A disabled lane does not take the computed value. It keeps the old destination value, which the caller presents on a third operand port. This lets vectorised conditional code run without branches. The result is registered, so it appears one cycle after issue together with a valid flag.

Top module: `simd_alu_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `result` is all zeros until the first issue.
- R2: Opcode 0 adds and opcode 1 subtracts each lane modulo 2^W. No carry or borrow passes from one lane into the next.
- R3: `lane_sz` selects the lane width W: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*W +: W].
- R4: Opcode 3 is an unsigned add and opcode 5 an unsigned subtract. Each lane clamps to 2^W-1 on overflow and to 0 on underflow.
- R5: Opcode 2 is a signed add and opcode 4 a signed subtract. Each lane clamps to the two's-complement limits of W bits, for example -128 and 127 at 8 bits.
- R6: Opcodes 6, 7, 8 and 9 compute A AND B, A OR B, A XOR B and A AND NOT B across all 64 bits.
- R7: When bit i of `lane_off` is 1, result lane i equals lane i of `dst_old`. Bits of `lane_off` at or above the lane count have no effect.
- R8: Opcode 10 (signed) and opcode 11 (unsigned) narrow every W-bit lane of A and B to W/2 bits with clamping. A's element i goes to bits [i*W/2 +: W/2]. B's element i goes to bits [32 + i*W/2 +: W/2].
- R9: Opcode 12 (low) and opcode 13 (high) take the W/2-bit elements from bits 0..31 (low) or bits 32..63 (high) of each source. Result lane i is {B element i, A element i}.
- R10: Opcodes 14 and 15 leave the destination unchanged: the result equals `dst_old`.
- R11: The result appears exactly one cycle after an issue with `in_valid` high, and `out_valid` follows `in_valid` with one cycle of delay. While `in_valid` is low, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| op | input | 4 | Operation code |
| lane_sz | input | 2 | Lane width select |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| dst_old | input | 64 | Previous destination contents, used by disabled lanes |
| lane_off | input | 8 | Per-lane disable bits |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result vector |

## Verification
The hardest case to reach is a lane-boundary fault. Here a carry, a clamp or a disable bit leaks into the neighbouring lane, but only at one particular lane width. Directed vectors therefore use values that sit right at a lane boundary, such as all ones plus one or extreme signed values. Each such vector is issued at several widths, so an error in how the operand is partitioned changes a byte the reference does not expect. Back-to-back issues with mixed widths, opcodes, masks and random operands then follow. This shows that the width select and the mask are sampled per issue.

// File: rtl/simd_pkg.sv
package simd_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_ADDS  = 4'd2,
      OP_ADDU  = 4'd3,
      OP_SUBS  = 4'd4,
      OP_SUBU  = 4'd5,
      OP_AND   = 4'd6,
      OP_OR    = 4'd7,
      OP_XOR   = 4'd8,
      OP_ANDN  = 4'd9,
      OP_PACKS = 4'd10,
      OP_PACKU = 4'd11,
      OP_UNPL  = 4'd12,
      OP_UNPH  = 4'd13,
      OP_RSV0  = 4'd14,
      OP_RSV1  = 4'd15
   } simd_op_e;

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
   import simd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  simd_op_e     op,
   output logic [W-1:0] y
);

   localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

   if (W < 2) begin : g_bad_w
      $error("simd_lane_alu: W must be at least 2");
   end

   logic [W:0] sum_x;
   logic [W:0] dif_x;
   logic       s_ovf_add;
   logic       s_ovf_sub;

   assign sum_x     = {1'b0, a} + {1'b0, b};
   assign dif_x     = {1'b0, a} - {1'b0, b};
   assign s_ovf_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
   assign s_ovf_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);

   always_comb begin
      unique case (op)
         OP_ADD:  y = sum_x[W-1:0];
         OP_SUB:  y = dif_x[W-1:0];
         OP_ADDS: y = s_ovf_add ? (a[W-1] ? S_MIN : S_MAX) : sum_x[W-1:0];
         OP_SUBS: y = s_ovf_sub ? (a[W-1] ? S_MIN : S_MAX) : dif_x[W-1:0];
         OP_ADDU: y = sum_x[W] ? '1 : sum_x[W-1:0];
         OP_SUBU: y = dif_x[W] ? '0 : dif_x[W-1:0];
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_ANDN: y = a & ~b;
         default: y = '0;
      endcase
   end

   // R4 / R5 checks on the lane result
   always_comb begin
      if (op == OP_ADDU) begin
         a_r4_usat_add_floor: assert (y >= a && y >= b);
      end
      if (op == OP_SUBU) begin
         a_r4_usat_sub_ceiling: assert (y <= a);
      end
      if (op == OP_ADDS && !a[W-1] && !b[W-1]) begin
         a_r5_ssat_add_nonneg: assert (!y[W-1]);
      end
      if (op == OP_ADDS && a[W-1] && b[W-1]) begin
         a_r5_ssat_add_neg: assert (y[W-1]);
      end
   end

endmodule

// File: rtl/simd_narrow.sv
module simd_narrow #(
   parameter int W = 16
) (
   input  logic [W-1:0]   x,
   input  logic           sgn,
   output logic [W/2-1:0] y
);

   localparam int H = W / 2;

   if (W % 2 != 0 || W < 4) begin : g_bad_w
      $error("simd_narrow: W must be even and at least 4");
   end

   logic          fits_s;
   logic          fits_u;
   logic [H-1:0]  y_s;
   logic [H-1:0]  y_u;

   assign fits_s = (&x[W-1:H-1]) | ~(|x[W-1:H-1]);
   assign fits_u = ~(|x[W-1:H]);
   assign y_s    = fits_s ? x[H-1:0]
                 : (x[W-1] ? {1'b1, {(H-1){1'b0}}} : {1'b0, {(H-1){1'b1}}});
   assign y_u    = fits_u ? x[H-1:0] : '1;
   assign y      = sgn ? y_s : y_u;

   // R8: an in-range signed value narrows without loss
   always_comb begin
      if (sgn && fits_s) begin
         a_r8_narrow_exact: assert ({{H{y[H-1]}}, y} == x);
      end
   end

endmodule

// File: rtl/simd_width_path.sv
module simd_width_path
   import simd_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int W      = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  simd_op_e          op,
   output logic [DATA_W-1:0] y
);

   localparam int N    = DATA_W / W;
   localparam int H    = W / 2;
   localparam int HALF = DATA_W / 2;

   if (DATA_W % W != 0 || W % 2 != 0) begin : g_bad_cfg
      $error("simd_width_path: W must be even and divide DATA_W");
   end

   logic [DATA_W-1:0] arith;
   logic [DATA_W-1:0] packed_v;
   logic [DATA_W-1:0] unp_lo;
   logic [DATA_W-1:0] unp_hi;
   logic              pk_sgn;

   assign pk_sgn = (op == OP_PACKS);

   for (genvar i = 0; i < N; i++) begin : g_lane
      simd_lane_alu #(.W(W)) u_lane (
         .a  (a[i*W +: W]),
         .b  (b[i*W +: W]),
         .op (op),
         .y  (arith[i*W +: W])
      );

      simd_narrow #(.W(W)) u_nar_a (
         .x   (a[i*W +: W]),
         .sgn (pk_sgn),
         .y   (packed_v[i*H +: H])
      );

      simd_narrow #(.W(W)) u_nar_b (
         .x   (b[i*W +: W]),
         .sgn (pk_sgn),
         .y   (packed_v[HALF + i*H +: H])
      );

      assign unp_lo[i*W +: W] = {b[i*H +: H], a[i*H +: H]};
      assign unp_hi[i*W +: W] = {b[HALF + i*H +: H], a[HALF + i*H +: H]};
   end

   always_comb begin
      unique case (op)
         OP_PACKS, OP_PACKU: y = packed_v;
         OP_UNPL:            y = unp_lo;
         OP_UNPH:            y = unp_hi;
         default:            y = arith;
      endcase
   end

endmodule

// File: rtl/simd_alu_unit.sv
module simd_alu_unit
   import simd_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int MIN_W  = 8,
   parameter int NSIZE  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [3:0]                  op,
   input  logic [$clog2(NSIZE)-1:0]    lane_sz,
   input  logic [DATA_W-1:0]           src_a,
   input  logic [DATA_W-1:0]           src_b,
   input  logic [DATA_W-1:0]           dst_old,
   input  logic [DATA_W/MIN_W-1:0]     lane_off,
   output logic                        out_valid,
   output logic [DATA_W-1:0]           result
);

   localparam int UNIT_N = DATA_W / MIN_W;
   localparam int SEL_W  = $clog2(NSIZE);

   if ((1 << SEL_W) != NSIZE) begin : g_bad_nsize
      $error("simd_alu_unit: NSIZE must be a power of two");
   end
   if (DATA_W % (MIN_W << (NSIZE - 1)) != 0) begin : g_bad_width
      $error("simd_alu_unit: widest lane must divide DATA_W");
   end
   if (MIN_W < 4 || MIN_W % 2 != 0) begin : g_bad_min
      $error("simd_alu_unit: MIN_W must be even and at least 4");
   end

   simd_op_e          opc;
   logic [DATA_W-1:0] path_y [NSIZE];
   logic [UNIT_N-1:0] keep_u [NSIZE];
   logic [DATA_W-1:0] sel_y;
   logic [UNIT_N-1:0] keep_sel;
   logic [DATA_W-1:0] wr_bits;
   logic              is_rsv;
   logic [DATA_W-1:0] nxt;

   assign opc = simd_op_e'(op);

   for (genvar s = 0; s < NSIZE; s++) begin : g_size
      simd_width_path #(.DATA_W(DATA_W), .W(MIN_W << s)) u_path (
         .a  (src_a),
         .b  (src_b),
         .op (opc),
         .y  (path_y[s])
      );
      for (genvar j = 0; j < UNIT_N; j++) begin : g_unit
         assign keep_u[s][j] = ~lane_off[j >> s];
      end
   end

   assign sel_y    = path_y[lane_sz];
   assign keep_sel = keep_u[lane_sz];
   assign is_rsv   = (opc == OP_RSV0) || (opc == OP_RSV1);

   for (genvar j = 0; j < UNIT_N; j++) begin : g_expand
      assign wr_bits[j*MIN_W +: MIN_W] = {MIN_W{keep_sel[j] & ~is_rsv}};
   end

   assign nxt = (sel_y & wr_bits) | (dst_old & ~wr_bits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= nxt;
         end
      end
   end

   // R7 / R10: bits not written come from the old destination
   a_r7_disabled_keep: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((result & ~$past(wr_bits)) == ($past(dst_old) & ~$past(wr_bits))));

   // R11: valid pipeline and hold
   a_r11_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r11_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

endmodule

// File: tb/sim_simd_alu_unit.sv
`timescale 1ns/1ps
module sim_simd_alu_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [1:0]  lane_sz = '0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [63:0] dst_old = '0;
   logic [7:0]  lane_off = '0;
   logic        out_valid;
   logic [63:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [63:0] exp_q [$];
   string       tag_q [$];
   logic [63:0] last_exp = '0;

   always #2.5 clk = ~clk;

   simd_alu_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .lane_sz(lane_sz), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
      .lane_off(lane_off), .out_valid(out_valid), .result(result)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [3:0] o, input logic [1:0] sz,
                                         input logic [63:0] a, input logic [63:0] b,
                                         input logic [63:0] d, input logic [7:0] off);
      int w, n, h, base;
      logic [63:0] r, dm;
      logic [67:0] lm, hm, ua, ub, t, ta, tb;
      logic signed [67:0] sa, sb, st, smax, smin, hmax, hmin;
      w = 8 << sz; n = 64 / w; h = w / 2;
      r = '0; dm = '0;
      lm = (68'd1 << w) - 68'd1;
      hm = (68'd1 << h) - 68'd1;
      smax = (68'sd1 <<< (w - 1)) - 68'sd1;
      smin = -(68'sd1 <<< (w - 1));
      hmax = (68'sd1 <<< (h - 1)) - 68'sd1;
      hmin = -(68'sd1 <<< (h - 1));
      for (int i = 0; i < n; i++) begin
         ua = ({4'b0, a} >> (i * w)) & lm;
         ub = ({4'b0, b} >> (i * w)) & lm;
         sa = ua[w-1] ? $signed(ua) - $signed(68'd1 << w) : $signed(ua);
         sb = ub[w-1] ? $signed(ub) - $signed(68'd1 << w) : $signed(ub);
         t = '0;
         case (o)
            4'd0: t = ua + ub;
            4'd1: t = ua - ub;
            4'd2, 4'd4: begin
               st = (o == 4'd2) ? sa + sb : sa - sb;
               if (st > smax) st = smax;
               else if (st < smin) st = smin;
               t = st;
            end
            4'd3: begin t = ua + ub; if (t > lm) t = lm; end
            4'd5: t = (ua < ub) ? 68'd0 : ua - ub;
            4'd6: t = ua & ub;
            4'd7: t = ua | ub;
            4'd8: t = ua ^ ub;
            4'd9: t = ua & ~ub;
            4'd10: begin
               st = sa; if (st > hmax) st = hmax; else if (st < hmin) st = hmin; ta = st;
               st = sb; if (st > hmax) st = hmax; else if (st < hmin) st = hmin; tb = st;
               r = r | 64'((ta & hm) << (i * h)) | 64'((tb & hm) << (32 + i * h));
            end
            4'd11: begin
               ta = (ua > hm) ? hm : ua;
               tb = (ub > hm) ? hm : ub;
               r = r | 64'(ta << (i * h)) | 64'(tb << (32 + i * h));
            end
            4'd12, 4'd13: begin
               base = (o == 4'd13) ? 32 : 0;
               ta = ({4'b0, a} >> (base + i * h)) & hm;
               tb = ({4'b0, b} >> (base + i * h)) & hm;
               t = (tb << h) | ta;
            end
            default: t = '0;
         endcase
         if (o != 4'd10 && o != 4'd11)
            r = r | 64'((t & lm) << (i * w));
         if (off[i] || o >= 4'd14)
            dm = dm | 64'(lm << (i * w));
      end
      return (r & ~dm) | (d & dm);
   endfunction

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1:           return "R2";
         4'd3, 4'd5:           return "R4";
         4'd2, 4'd4:           return "R5";
         4'd6, 4'd7, 4'd8, 4'd9: return "R6";
         4'd10, 4'd11:         return "R8";
         4'd12, 4'd13:         return "R9";
         default:              return "R10";
      endcase
   endfunction

   // driver: issues one operation and pushes its expected result
   task automatic issue(input string tag, input logic [3:0] o, input logic [1:0] sz,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] d, input logic [7:0] off);
      @(negedge clk);
      op = o; lane_sz = sz; src_a = a; src_b = b; dst_old = d; lane_off = off;
      in_valid = 1'b1;
      exp_q.push_back(model(o, sz, a, b, d, off));
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // monitor: compares each result as it emerges
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
               check("R11 unexpected out_valid", 64'd1, 64'd0);
            end else begin
               last_exp = exp_q.pop_front();
               check(tag_q.pop_front(), result, last_exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 result in reset", result, 64'd0);
      check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 result after reset", result, 64'd0);
      check("R1 valid after reset", {63'd0, out_valid}, 64'd0);

      // R2 wrapping, lane isolation
      issue("R2 add8",  4'd0, 2'd0, 64'hFF01_80FF_7F00_12FF, 64'h0101_8001_0100_0101, 64'h0, 8'h00);
      issue("R2 sub16", 4'd1, 2'd1, 64'h0000_8000_FFFF_1234, 64'h0001_0001_0001_0235, 64'h0, 8'h00);
      // R3 same operands at each width
      issue("R3 w8",  4'd0, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 8'h00);
      issue("R3 w16", 4'd0, 2'd1, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 8'h00);
      issue("R3 w32", 4'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 8'h00);
      issue("R3 w64", 4'd0, 2'd3, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 8'h00);
      // R4 unsigned clamp
      issue("R4 addu8",  4'd3, 2'd0, 64'hF0F0_0101_FF00_8080, 64'h2010_FEFF_0100_8080, 64'h0, 8'h00);
      issue("R4 subu16", 4'd5, 2'd1, 64'h0005_FFFF_0000_1234, 64'h0006_0001_0001_1234, 64'h0, 8'h00);
      // R5 signed clamp
      issue("R5 adds8",  4'd2, 2'd0, 64'h7F80_7F80_0102_FE05, 64'h01FF_7F80_7F80_FEFB, 64'h0, 8'h00);
      issue("R5 subs16", 4'd4, 2'd1, 64'h8000_7FFF_0010_FFFF, 64'h0001_FFFF_0020_8000, 64'h0, 8'h00);
      issue("R5 adds64", 4'd2, 2'd3, 64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0100, 64'h0, 8'h00);
      // R6 logic
      issue("R6 and",  4'd6, 2'd3, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 64'h0, 8'h00);
      issue("R6 or",   4'd7, 2'd2, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 64'h0, 8'h00);
      issue("R6 xor",  4'd8, 2'd0, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 64'h0, 8'h00);
      issue("R6 andn", 4'd9, 2'd1, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 64'h0, 8'h00);
      // R7 lane disable
      issue("R7 mask8",  4'd0, 2'd0, 64'h1111_1111_1111_1111, 64'h0101_0101_0101_0101, 64'hDEAD_BEEF_CAFE_F00D, 8'hA5);
      issue("R7 mask16 high bits ignored", 4'd1, 2'd1, 64'h5555_5555_5555_5555, 64'h1111_1111_1111_1111, 64'hDEAD_BEEF_CAFE_F00D, 8'hF0);
      issue("R7 mask32", 4'd7, 2'd2, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'hDEAD_BEEF_CAFE_F00D, 8'h02);
      issue("R7 mask64", 4'd3, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'hDEAD_BEEF_CAFE_F00D, 8'h01);
      // R8 pack
      issue("R8 packs16", 4'd10, 2'd1, 64'h0080_FF7F_007F_FFFF, 64'h8000_7FFF_FF80_0001, 64'h0, 8'h00);
      issue("R8 packu16", 4'd11, 2'd1, 64'h0100_00FF_0012_FFFF, 64'h0000_8000_00AB_0001, 64'h0, 8'h00);
      issue("R8 packs8",  4'd10, 2'd0, 64'h8007_F8FF_0907_7F01, 64'h0102_0304_F0F8_0F08, 64'h0, 8'h00);
      issue("R8 packs64", 4'd10, 2'd3, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_8000_0000, 64'h0, 8'h00);
      // R9 unpack
      issue("R9 unpl16", 4'd12, 2'd1, 64'h1111_2222_3344_5566, 64'hAAAA_BBBB_CCDD_EEFF, 64'h0, 8'h00);
      issue("R9 unph8",  4'd13, 2'd0, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 64'h0, 8'h00);
      issue("R9 unpl64", 4'd12, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 64'h0, 8'h00);
      // R10 reserved
      issue("R10 rsv14", 4'd14, 2'd0, 64'h1, 64'h2, 64'h0123_4567_89AB_CDEF, 8'h00);
      issue("R10 rsv15", 4'd15, 2'd3, 64'h1, 64'h2, 64'hFEDC_BA98_7654_3210, 8'h00);
      idle();
      repeat (3) @(negedge clk);
      check("R11 hold result while idle", result, last_exp);
      check("R11 valid low while idle", {63'd0, out_valid}, 64'd0);

      // mixed random stream, back to back
      for (int k = 0; k < 60; k++) begin
         logic [3:0] ro;
         ro = 4'($urandom_range(0, 15));
         issue(tag_of(ro), ro, 2'($urandom_range(0, 3)),
               {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
               (k % 3 == 0) ? 8'($urandom) : 8'h00);
      end
      idle();
      repeat (3) @(negedge clk);
      check("R11 queue drained", 64'(exp_q.size()), 64'd0);
      finish_run();
   end

endmodule